// File: doc/BRIEF.md
# Adjustable-Rate Nanosecond Time Counter

This block keeps a free-running time-of-day value for precision time stamping. On each enabled reference clock it adds a small programmable step to an accumulator. To trim the rate, software picks a second step value and a spacing. On one clock out of every spacing-plus-one enabled clocks, the block adds the second step instead of the normal one. Over a long run this shifts the average rate by a fine fraction.

The accumulator wraps in one of two ways. It can wrap at full width. It can also wrap at a software-chosen period, which lets it count within one second or within a 31-bit range. On each wrap the block can emit a one-cycle event that compare channels use to re-arm.

Software reaches the block through a small word-addressed register port. Through this port it can:
- load the counter directly,
- restart the counter from zero,
- freeze a coherent copy of the counter for reading.

Top module: `tod_counter`

## Requirements
- R1: After reset every mapped register reads zero and the wrap event output is low.
- R2: With the enable bit (control bit 0) set, the counter advances by one step on each clock. With the enable bit clear, it holds its value.
- R3: The increment register (address 4) holds the normal step in bits 6:0 and the correction step in bits 14:8. When the correction spacing register (address 3) holds a nonzero value P, an internal cycle count decides which step is used. While that count is below P, the normal step is used and the count rises by one. When the count has reached or passed P, the correction step is used and the count returns to zero. After a restart, this gives the pattern of P normal steps followed by one correction step.
- R4: A correction spacing of zero means the normal step is used on every clock.
- R5: When control bit 4 is set and the period register (address 2) is nonzero, the period rule applies. Any advance whose sum reaches or exceeds the period stores the sum minus the period and counts as a wrap. Control bit 5 is stored and read back but has no effect. A period of zero falls back to full-width wrapping.
- R6: Without the period rule, the counter wraps modulo 2^CNT_W, and a carry out of the top bit counts as a wrap.
- R7: The wrap event output is high for the one cycle after the clock edge on which a wrap happened, and only while control bit 7 is set.
- R8: Writing control bit 11 copies the counter value present at that write's clock edge into a snapshot. Reads of address 1 return the snapshot. Bit 11 always reads back as zero.
- R9: A write to address 1 loads the counter with the written value at that edge. It takes priority over advance and restart, and it leaves the correction cycle count unchanged.
- R10: Writing control bit 9 clears the counter and the correction cycle count at that edge. Bit 9 always reads back as zero.
- R11: The register map is control at address 0, counter snapshot at 1, period at 2, correction spacing at 3 and increment at 4. Control reads back only bits 0, 4, 5 and 7. The correction spacing keeps its low CORR_W bits. Addresses 5 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| wrap_evt_o | output | 1 | One-cycle wrap event for compare channels |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 7-bit steps and a 31-bit correction spacing. Natural full-width wraps would take far too many cycles to reach. Counter loads close to the top of the range bring carry wraps within a few clocks instead. Small random periods and spacings of zero to six make period wraps and correction cycles happen many times in each random burst.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned ADDR_W      = 3;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned CORR_LSB    = 8;

    // control bit positions
    localparam int unsigned BIT_EN      = 0;
    localparam int unsigned BIT_PMODE   = 4;
    localparam int unsigned BIT_PMODE_X = 5;
    localparam int unsigned BIT_CMP     = 7;
    localparam int unsigned BIT_RESTART = 9;
    localparam int unsigned BIT_CAPTURE = 11;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_COUNT  = 3'd1,
        A_PERIOD = 3'd2,
        A_CORR   = 3'd3,
        A_INC    = 3'd4
    } addr_e;

    typedef struct packed {
        logic cmp_en;
        logic pmode_x;
        logic pmode;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned CORR_W = 31,
    parameter int unsigned INC_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [CNT_W-1:0]    snap_i,
    output ctrl_t               ctrl_o,
    output logic [CNT_W-1:0]    period_o,
    output logic [CORR_W-1:0]   corr_per_o,
    output logic [INC_W-1:0]    inc_n_o,
    output logic [INC_W-1:0]    inc_c_o,
    output logic                load_o,
    output logic [CNT_W-1:0]    load_val_o,
    output logic                restart_o,
    output logic                capture_o,
    output logic [DATA_W-1:0]   rdata_o
);

    typedef struct packed {
        ctrl_t               ctrl;
        logic [CNT_W-1:0]    per;
        logic [CORR_W-1:0]   corr;
        logic [INC_W-1:0]    inc_n;
        logic [INC_W-1:0]    inc_c;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d      = st_q;
        load_o    = 1'b0;
        restart_o = 1'b0;
        capture_o = 1'b0;
        if (wr_en_i) begin
            case (addr_i)
                A_CTRL: begin
                    st_d.ctrl.en      = wdata_i[BIT_EN];
                    st_d.ctrl.pmode   = wdata_i[BIT_PMODE];
                    st_d.ctrl.pmode_x = wdata_i[BIT_PMODE_X];
                    st_d.ctrl.cmp_en  = wdata_i[BIT_CMP];
                    restart_o         = wdata_i[BIT_RESTART];
                    capture_o         = wdata_i[BIT_CAPTURE];
                end
                A_COUNT:  load_o     = 1'b1;
                A_PERIOD: st_d.per   = wdata_i[CNT_W-1:0];
                A_CORR:   st_d.corr  = wdata_i[CORR_W-1:0];
                A_INC: begin
                    st_d.inc_n = wdata_i[INC_W-1:0];
                    st_d.inc_c = wdata_i[CORR_LSB +: INC_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[BIT_EN]      = st_q.ctrl.en;
                rdata_o[BIT_PMODE]   = st_q.ctrl.pmode;
                rdata_o[BIT_PMODE_X] = st_q.ctrl.pmode_x;
                rdata_o[BIT_CMP]     = st_q.ctrl.cmp_en;
            end
            A_COUNT:  rdata_o = DATA_W'(snap_i);
            A_PERIOD: rdata_o = DATA_W'(st_q.per);
            A_CORR:   rdata_o = DATA_W'(st_q.corr);
            A_INC: begin
                rdata_o[INC_W-1:0]         = st_q.inc_n;
                rdata_o[CORR_LSB +: INC_W] = st_q.inc_c;
            end
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o     = st_q.ctrl;
    assign period_o   = st_q.per;
    assign corr_per_o = st_q.corr;
    assign inc_n_o    = st_q.inc_n;
    assign inc_c_o    = st_q.inc_c;
    assign load_val_o = wdata_i[CNT_W-1:0];

    // R11: settings move only through a write to a mapped address
    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || addr_i > A_INC) |=> $stable(st_q));

endmodule

// File: rtl/tod_rate.sv
module tod_rate #(
    parameter int unsigned CORR_W = 31,
    parameter int unsigned INC_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              clr_i,
    input  logic [CORR_W-1:0] corr_per_i,
    input  logic [INC_W-1:0]  inc_n_i,
    input  logic [INC_W-1:0]  inc_c_i,
    output logic [INC_W-1:0]  step_o
);

    typedef struct packed {
        logic [CORR_W-1:0] cyc;
    } rate_t;

    rate_t s_d, s_q;
    logic  corr_off;
    logic  corr_due;

    assign corr_off = (corr_per_i == '0);
    assign corr_due = !corr_off && (s_q.cyc >= corr_per_i);

    always_comb begin
        s_d    = s_q;
        step_o = corr_due ? inc_c_i : inc_n_i;
        if (clr_i) begin
            s_d.cyc = '0;
        end else if (adv_i) begin
            if (corr_off || corr_due) s_d.cyc = '0;
            else                      s_d.cyc = s_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: with correction off the cycle count sits at zero
    p_idle_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_off && adv_i) |=> (s_q.cyc == '0));

    // R3: the cycle count never runs past the spacing it was counting toward
    p_cycle_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !corr_off && s_q.cyc < corr_per_i) |=> (s_q.cyc <= $past(corr_per_i)));

    // R10: restart clears the cycle count
    p_restart_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cyc == '0));

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [INC_W-1:0]  step_i,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic              restart_i,
    input  logic              capture_i,
    input  logic              pmode_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic [CNT_W-1:0]  snap_o,
    output logic              wrap_o
);

    localparam int unsigned SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             wrap;
    } acc_t;

    acc_t             a_d, a_q;
    logic [SUM_W-1:0] sum;
    logic             use_per;
    logic             hit;

    assign use_per = pmode_i && (period_i != '0);

    always_comb begin
        a_d  = a_q;
        sum  = SUM_W'(a_q.cnt) + SUM_W'(step_i);
        hit  = use_per ? (sum >= SUM_W'(period_i)) : sum[CNT_W];
        a_d.wrap = 1'b0;
        if (capture_i) a_d.snap = a_q.cnt;
        if (load_i) begin
            a_d.cnt = load_val_i;
        end else if (restart_i) begin
            a_d.cnt = '0;
        end else if (adv_i) begin
            a_d.wrap = hit;
            if (use_per && hit) a_d.cnt = CNT_W'(sum - SUM_W'(period_i));
            else                a_d.cnt = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign snap_o = a_q.snap;
    assign wrap_o = a_q.wrap;

    // R2: no run, no load, no restart: the counter holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i && !restart_i) |=> $stable(a_q.cnt));

    // R9: a load lands exactly
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (a_q.cnt == $past(load_val_i)));

    // R10: restart without load clears the counter
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !load_i) |=> (a_q.cnt == '0));

    // R5: a value inside the period stays inside it after an advance
    p_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !restart_i && use_per && a_q.cnt < period_i
         && CNT_W'(step_i) <= period_i) |=> (a_q.cnt < $past(period_i)));

    // R8: the snapshot changes only on a capture
    p_snap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(a_q.snap));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned CORR_W = 31,
    parameter int unsigned INC_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                wrap_evt_o
);

    ctrl_t              ctrl;
    logic [CNT_W-1:0]   period;
    logic [CORR_W-1:0]  corr_per;
    logic [INC_W-1:0]   inc_n;
    logic [INC_W-1:0]   inc_c;
    logic [INC_W-1:0]   step;
    logic               load;
    logic [CNT_W-1:0]   load_val;
    logic               restart;
    logic               capture;
    logic               adv;
    logic [CNT_W-1:0]   snap;
    logic               wrap;

    tod_regs #(.CNT_W(CNT_W), .CORR_W(CORR_W), .INC_W(INC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .snap_i     (snap),
        .ctrl_o     (ctrl),
        .period_o   (period),
        .corr_per_o (corr_per),
        .inc_n_o    (inc_n),
        .inc_c_o    (inc_c),
        .load_o     (load),
        .load_val_o (load_val),
        .restart_o  (restart),
        .capture_o  (capture),
        .rdata_o    (reg_rdata_o)
    );

    assign adv = ctrl.en && !load && !restart;

    tod_rate #(.CORR_W(CORR_W), .INC_W(INC_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .clr_i      (restart && !load),
        .corr_per_i (corr_per),
        .inc_n_i    (inc_n),
        .inc_c_i    (inc_c),
        .step_o     (step)
    );

    tod_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .step_i     (step),
        .load_i     (load),
        .load_val_i (load_val),
        .restart_i  (restart),
        .capture_i  (capture),
        .pmode_i    (ctrl.pmode),
        .period_i   (period),
        .snap_o     (snap),
        .wrap_o     (wrap)
    );

    assign wrap_evt_o = wrap && ctrl.cmp_en;

    // R7: an event follows a clock on which the counter was running
    p_evt_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt_o |-> $past(ctrl.en));

endmodule

// File: tb/tod_counter_bench.sv
module tod_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wrap_evt;

    int n_chk  = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;
    logic [31:0] cur_ctrl = '0;

    always #5 clk = ~clk;

    tod_counter u_tod_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wrap_evt_o(wrap_evt)
    );

    // reference state derived from the requirements
    logic        m_en, m_pm, m_px, m_cmp, m_wrap;
    logic [31:0] m_cnt, m_snap, m_per;
    logic [30:0] m_corr, m_cyc;
    logic [6:0]  m_in, m_ic;

    always @(posedge clk) begin
        logic ld, rs, cp, adv, hit, use_per;
        logic [6:0]  step;
        logic [32:0] sum;
        logic [31:0] ncnt;
        logic [30:0] ncyc;
        if (!rst_n) begin
            m_en = 0; m_pm = 0; m_px = 0; m_cmp = 0; m_wrap = 0;
            m_cnt = 0; m_snap = 0; m_per = 0; m_corr = 0; m_cyc = 0;
            m_in = 0; m_ic = 0;
        end else begin
            ld  = wr && addr == 3'd1;
            rs  = wr && addr == 3'd0 && wdata[9];
            cp  = wr && addr == 3'd0 && wdata[11];
            adv = m_en && !ld && !rs;
            step = m_in; ncyc = m_cyc;
            if (m_corr != 0 && m_cyc >= m_corr) step = m_ic;
            if (rs && !ld) ncyc = 0;
            else if (adv) ncyc = (m_corr == 0 || m_cyc >= m_corr) ? 31'd0 : m_cyc + 1;
            use_per = m_pm && m_per != 0;
            sum = {1'b0, m_cnt} + {26'd0, step};
            hit = use_per ? (sum >= {1'b0, m_per}) : sum[32];
            if (ld) ncnt = wdata;
            else if (rs) ncnt = 0;
            else if (adv) ncnt = (use_per && hit) ? 32'(sum - {1'b0, m_per}) : sum[31:0];
            else ncnt = m_cnt;
            if (cp) m_snap = m_cnt;
            m_wrap = adv && hit;
            m_cnt = ncnt; m_cyc = ncyc;
            if (wr) case (addr)
                3'd0: begin m_en = wdata[0]; m_pm = wdata[4]; m_px = wdata[5]; m_cmp = wdata[7]; end
                3'd2: m_per = wdata;
                3'd3: m_corr = wdata[30:0];
                3'd4: begin m_in = wdata[6:0]; m_ic = wdata[14:8]; end
                default: ;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // R7: event output compared every cycle
    always @(negedge clk) if (rst_n && chk_on) chk("R7 wrap event", {31'd0, wrap_evt}, {31'd0, m_wrap & m_cmp});

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); wr = 1'b0; addr = a; #1 d = rdata;
    endtask

    task automatic set_ctrl(input logic [31:0] c);
        cur_ctrl = c & 32'h0000_00B1;
        wreg(3'd0, c);
    endtask

    task automatic snap_check(input string tag);
        logic [31:0] v;
        wreg(3'd0, cur_ctrl | 32'h800);
        rreg(3'd1, v);
        chk(tag, v, m_snap);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), v);
            chk("R1 reset read", v, 32'd0);
        end
        chk("R1 wrap low", {31'd0, wrap_evt}, 32'd0);
        chk_on = 1'b1;

        // R3: steps 2 and 5, spacing 1 -> +2,+5,+2,+5,+2 = 16
        wreg(3'd4, 32'h0000_0502);
        wreg(3'd3, 32'd1);
        set_ctrl(32'h0000_0201);
        repeat (4) @(negedge clk);
        wreg(3'd0, cur_ctrl | 32'h800);
        rreg(3'd1, v);
        chk("R3 correction pattern", v, 32'd16);

        // R4: spacing 0 -> five normal steps = 10
        wreg(3'd3, 32'd0);
        set_ctrl(32'h0000_0201);
        repeat (4) @(negedge clk);
        wreg(3'd0, cur_ctrl | 32'h800);
        rreg(3'd1, v);
        chk("R4 no correction", v, 32'd10);

        // R2: disabled counter holds
        set_ctrl(32'h0);
        snap_check("R2 hold first");
        v = m_snap;
        repeat (7) @(negedge clk);
        wreg(3'd0, 32'h800);
        rreg(3'd1, v2);
        chk("R2 hold value", v2, v);
        set_ctrl(32'h1);
        repeat (9) @(negedge clk);
        snap_check("R2 running");

        // R10: restart then capture -> one normal step (2)
        wreg(3'd0, 32'h0000_0201);
        wreg(3'd0, 32'h0000_0801);
        rreg(3'd1, v);
        chk("R10 restart", v, 32'd2);
        rreg(3'd0, v);
        chk("R10 R8 self clear", v, 32'h1);

        // R9: load while running, step 4 -> 1004
        wreg(3'd4, 32'h4);
        wreg(3'd1, 32'd1000);
        wreg(3'd0, 32'h0000_0801);
        rreg(3'd1, v);
        chk("R9 load", v, 32'd1004);

        // R6 and R7: carry wrap with events on, then off
        set_ctrl(32'h81);
        wreg(3'd1, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R6 carry event", {31'd0, wrap_evt}, 32'd1);
        @(negedge clk);
        chk("R7 one cycle", {31'd0, wrap_evt}, 32'd0);
        set_ctrl(32'h01);
        wreg(3'd1, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R7 gated off", {31'd0, wrap_evt}, 32'd0);
        snap_check("R6 wrapped value");

        // R5: period 10, step 4, load 8 -> 2 with event
        wreg(3'd2, 32'd10);
        set_ctrl(32'h91);
        wreg(3'd1, 32'd8);
        wreg(3'd0, cur_ctrl | 32'h800);
        rreg(3'd1, v);
        chk("R5 period wrap", v, 32'd2);
        // R5: period zero falls back to full width
        wreg(3'd2, 32'd0);
        wreg(3'd1, 32'd8);
        wreg(3'd0, cur_ctrl | 32'h800);
        rreg(3'd1, v);
        chk("R5 zero period", v, 32'd12);

        // R11: field masks and unmapped addresses
        wreg(3'd4, 32'hFFFF_FFFF);
        rreg(3'd4, v);
        chk("R11 inc fields", v, 32'h0000_7F7F);
        wreg(3'd3, 32'hFFFF_FFFF);
        rreg(3'd3, v);
        chk("R11 corr width", v, 32'h7FFF_FFFF);
        wreg(3'd0, 32'hFFFF_F5FF);
        rreg(3'd0, v);
        chk("R11 ctrl bits", v, 32'h0000_00B1);
        cur_ctrl = 32'hB1;
        for (int a = 5; a < 8; a++) begin
            wreg(3'(a), 32'hA5A5_5A5A);
            rreg(3'(a), v);
            chk("R11 unmapped", v, 32'd0);
        end
        wreg(3'd2, 32'd0);
        rreg(3'd2, v);
        chk("R11 period readback", v, 32'd0);

        // random mix, compared with the reference state
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 7);
            case (op)
                0: wreg(3'd4, $urandom());
                1: wreg(3'd3, $urandom_range(0, 6));
                2: wreg(3'd2, ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom_range(1, 300));
                3: set_ctrl(($urandom() & 32'h0000_02B0) | 32'h1 | ($urandom_range(0, 5) == 0 ? 32'h0 : 32'h0));
                4: wreg(3'd1, ($urandom_range(0, 1) == 0) ? $urandom() : (32'hFFFF_FF00 | $urandom_range(0, 255)));
                default: ;
            endcase
            repeat ($urandom_range(0, 20)) @(negedge clk);
            snap_check("R2 R3 R5 R6 random");
        end

        chk_on = 1'b0;
        report();
    end

endmodule